// File: doc/BRIEF.md
# Narrow-Slave Write Steering Sequencer

This block takes over a write from a 16-bit bus master when the addressed device does not claim the cycle as a 16-bit or 32-bit wide slave. That means the device is an 8-bit slave that only listens on byte lane 0. When data time starts, the block captures both bytes the master placed on lanes 0 and 1, so the master may release the data bus and byte enables. It then runs up to two narrow cycles on its own. It rebuilds the low address bits and the high-byte enable for each cycle, and it passes the lane-1 byte down onto lane 0 for the second cycle.

The narrow cycles run in order. The first presents the lane-0 byte. A restart cycle then drops the command and pulses a fresh start so that the slave sees a new cycle. The second cycle presents the copied-down lane-1 byte. Each cycle ends on a zero-wait indication or on the slave's ready line. If the slave never responds, a programmable timeout abandons the sequence and raises an error flag. When the sequence ends, the block asserts both wide-acknowledge outputs for one cycle, which tells the master it may finish its cycle. The master keeps the address, memory/IO and write attributes stable throughout.

All control ports are active high except `nar_bhe_n`. The block models one clock cycle for each bus phase, and its outputs are decoded from a registered state.

Top module: `nws_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, every strobe, enable, command and acknowledge output is low. `nar_bhe_n` is 1, `nar_data` is 0 and `tmo_err` is 0.
- R2: The cycle after `mst_start`, the block takes over only if all of these hold: `mst_is16`=1, `mst_write`=1, `slv_wide16`=0, `slv_wide32`=0 and `mst_be`≠0. Otherwise no output other than the idle values appears, whatever the slave ready inputs do.
- R3: In the cycle of takeover, both bits of `lane_lat` are 1, and `mst_data[7:0]` and `mst_data[15:8]` are captured. Bytes presented later come from these captures, whatever the master drives afterwards.
- R4: The first narrow cycle presents the lane-0 byte on `nar_data` with `lane0_oe`=1, `nar_a0`=0, `nar_a1`=0 and `nar_bhe_n`=0. It asserts `nar_mem_wr` if `mst_mem` was 1 at takeover, otherwise `nar_io_wr`. `steer_busy` is 1 from that cycle through the acknowledge cycle.
- R5: A narrow cycle consists of one command cycle and then wait cycles. If `slv_nows` is 1 during the command cycle, exactly one wait cycle follows, whatever `slv_chrdy` does.
- R6: Otherwise the narrow cycle stays in its wait cycles until `slv_chrdy` is 1 in a wait cycle, and that is the last wait cycle.
- R7: When both lanes are enabled, exactly one restart cycle separates the two narrow cycles. In it the command outputs are 0, `nar_start`=1, `nar_a0`=1 and `nar_bhe_n`=0.
- R8: The second narrow cycle presents the captured lane-1 byte on `nar_data` with `lane1_oe`=1, `copy_dn_en`=1, `nar_a0`=1 and `nar_bhe_n`=0. All of these drop when the cycle ends.
- R9: When `mst_be`=01, only the first narrow cycle runs. When `mst_be`=10, only the second runs, directly after takeover and with no restart cycle.
- R10: The cycle after the last narrow cycle ends, `ack_wide16` and `ack_wide32` are both 1 for exactly one cycle. The block is idle in the next cycle.
- R11: If a narrow cycle gets no ready indication in `tmo_limit`+1 consecutive wait cycles, it is abandoned after the last of them. Any remaining cycle is skipped, the acknowledge cycle follows, and `tmo_err` becomes 1. `tmo_err` stays 1 until the cycle after the next takeover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_start | input | 1 | Master address-phase start, one cycle |
| mst_is16 | input | 1 | The current master is 16 bits wide |
| mst_write | input | 1 | 1 = write cycle |
| mst_mem | input | 1 | 1 = memory space, 0 = I/O space |
| mst_be | input | 2 | Byte enables for lanes 1:0, active high |
| mst_data | input | 2*LANE_W | Master data on lanes 1:0 |
| slv_wide16 | input | 1 | Slave claimed a 16-bit wide cycle |
| slv_wide32 | input | 1 | Slave claimed a 32-bit wide cycle |
| slv_nows | input | 1 | Zero-wait request from the narrow slave |
| slv_chrdy | input | 1 | Narrow slave ready |
| tmo_limit | input | TMO_W | Timeout limit, in wait cycles beyond the first |
| lane_lat | output | 2 | Capture strobes for the lane latches |
| lane0_oe | output | 1 | Drive the lane-0 latch onto lane 0 |
| lane1_oe | output | 1 | Drive the lane-1 latch |
| copy_dn_en | output | 1 | Copy lane 1 down onto lane 0 |
| nar_start | output | 1 | Regenerated start pulse |
| nar_mem_wr | output | 1 | Narrow memory-write command |
| nar_io_wr | output | 1 | Narrow I/O-write command |
| nar_a0 | output | 1 | Narrow address bit 0 |
| nar_a1 | output | 1 | Narrow address bit 1 |
| nar_bhe_n | output | 1 | High-byte enable, active low |
| nar_data | output | LANE_W | Byte presented on lane 0 |
| ack_wide16 | output | 1 | Hand back to the master (16-bit acknowledge) |
| ack_wide32 | output | 1 | Hand back to the master (32-bit acknowledge) |
| steer_busy | output | 1 | A steering sequence is running |
| tmo_err | output | 1 | Sticky timeout flag |

## Verification
The bench drives a zero-wait request with the ready line held low. A design that merged the two ready paths would then hang in the wait state, or leave it too early when ready arrives in the first wait cycle. Single-lane enables check that a wrong design does not insert a stray restart cycle or present a stale second byte. After takeover the bench replaces the master data with different values, which exposes a design that reads the live bus instead of its latches. A timeout that lands in the first of two cycles must skip the second cycle, raise the flag, and clear the flag only after the next takeover. An off-by-one counter would show up as one wait cycle too many or too few.

// File: rtl/nws_pkg.sv
package nws_pkg;
   localparam int NWS_LANES = 2;

   typedef enum logic [7:0] {
      ST_IDLE    = 8'h01,
      ST_LATCH   = 8'h02,
      ST_X0_CMD  = 8'h04,
      ST_X0_WAIT = 8'h08,
      ST_RESTART = 8'h10,
      ST_X1_CMD  = 8'h20,
      ST_X1_WAIT = 8'h40,
      ST_DONE    = 8'h80
   } nws_state_e;
endpackage

// File: rtl/nws_lane_bank.sv
module nws_lane_bank #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        cap,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] q
);
   if (LANES < 1) begin : g_bad_lanes
      $error("nws_lane_bank: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("nws_lane_bank: LANE_W must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hold_q <= '0;
         else if (cap[i]) hold_q <= din[i*LANE_W +: LANE_W];
      end
      assign q[i*LANE_W +: LANE_W] = hold_q;
   end
endmodule

// File: rtl/nws_wait_timer.sv
module nws_wait_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_wait,
   input  logic             ready,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   if (TMO_W < 1) begin : g_bad_tmo
      $error("nws_wait_timer: TMO_W must be at least 1");
   end

   logic [TMO_W-1:0] cnt_q;

   assign expired = in_wait && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!in_wait || ready || expired) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && $stable(limit)) |-> (cnt_q <= limit));
endmodule

// File: rtl/nws_ctrl.sv
module nws_ctrl
   import nws_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mst_start,
   input  logic       mst_is16,
   input  logic       mst_write,
   input  logic       slv_wide16,
   input  logic       slv_wide32,
   input  logic [1:0] mst_be,
   input  logic       slv_nows,
   input  logic       slv_chrdy,
   input  logic       tmo_expired,
   output nws_state_e state_q,
   output logic       accept,
   output logic       in_wait,
   output logic       ready,
   output logic       timeout_hit
);
   nws_state_e state_d;
   logic       fast_q;
   logic [1:0] be_q;

   assign accept      = (state_q == ST_LATCH) && mst_is16 && mst_write &&
                        !slv_wide16 && !slv_wide32 && (mst_be != 2'b00);
   assign in_wait     = (state_q == ST_X0_WAIT) || (state_q == ST_X1_WAIT);
   assign ready       = in_wait && (fast_q || slv_chrdy);
   assign timeout_hit = in_wait && !ready && tmo_expired;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (mst_start) state_d = ST_LATCH;
         ST_LATCH: begin
            if (!accept)        state_d = ST_IDLE;
            else if (mst_be[0]) state_d = ST_X0_CMD;
            else                state_d = ST_X1_CMD;
         end
         ST_X0_CMD:  state_d = ST_X0_WAIT;
         ST_X0_WAIT: begin
            if (ready)            state_d = be_q[1] ? ST_RESTART : ST_DONE;
            else if (timeout_hit) state_d = ST_DONE;
         end
         ST_RESTART: state_d = ST_X1_CMD;
         ST_X1_CMD:  state_d = ST_X1_WAIT;
         ST_X1_WAIT: if (ready || timeout_hit) state_d = ST_DONE;
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fast_q  <= 1'b0;
         be_q    <= 2'b00;
      end else begin
         state_q <= state_d;
         if (accept) be_q <= mst_be;
         if (state_q == ST_X0_CMD || state_q == ST_X1_CMD) fast_q <= slv_nows;
         else if (state_q == ST_IDLE)                      fast_q <= 1'b0;
      end
   end

   assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(state_q));
   assert_fast_one_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_X0_CMD || state_q == ST_X1_CMD) && slv_nows) |=> ##1 !in_wait);
   assert_skip_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mst_be == 2'b10) |=> (state_q == ST_X1_CMD));
endmodule

// File: rtl/nws_seq.sv
module nws_seq
   import nws_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int TMO_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mst_start,
   input  logic                mst_is16,
   input  logic                mst_write,
   input  logic                mst_mem,
   input  logic [1:0]          mst_be,
   input  logic [2*LANE_W-1:0] mst_data,
   input  logic                slv_wide16,
   input  logic                slv_wide32,
   input  logic                slv_nows,
   input  logic                slv_chrdy,
   input  logic [TMO_W-1:0]    tmo_limit,
   output logic [1:0]          lane_lat,
   output logic                lane0_oe,
   output logic                lane1_oe,
   output logic                copy_dn_en,
   output logic                nar_start,
   output logic                nar_mem_wr,
   output logic                nar_io_wr,
   output logic                nar_a0,
   output logic                nar_a1,
   output logic                nar_bhe_n,
   output logic [LANE_W-1:0]   nar_data,
   output logic                ack_wide16,
   output logic                ack_wide32,
   output logic                steer_busy,
   output logic                tmo_err
);
   localparam int DATA_W = NWS_LANES * LANE_W;

   if (LANE_W < 1 || LANE_W > 64) begin : g_bad_lane_w
      $error("nws_seq: LANE_W out of range");
   end
   if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo_w
      $error("nws_seq: TMO_W out of range");
   end

   nws_state_e       state_q;
   logic             accept, in_wait, ready, timeout_hit, tmo_expired;
   logic             mem_q, err_q;
   logic [DATA_W-1:0] held;
   logic             in_x0, in_x1, cmd_on, in_rst, in_done;

   nws_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mst_start   (mst_start),
      .mst_is16    (mst_is16),
      .mst_write   (mst_write),
      .slv_wide16  (slv_wide16),
      .slv_wide32  (slv_wide32),
      .mst_be      (mst_be),
      .slv_nows    (slv_nows),
      .slv_chrdy   (slv_chrdy),
      .tmo_expired (tmo_expired),
      .state_q     (state_q),
      .accept      (accept),
      .in_wait     (in_wait),
      .ready       (ready),
      .timeout_hit (timeout_hit)
   );

   nws_wait_timer #(.TMO_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_wait (in_wait),
      .ready   (ready),
      .limit   (tmo_limit),
      .expired (tmo_expired)
   );

   nws_lane_bank #(.LANES(NWS_LANES), .LANE_W(LANE_W)) u_lanes (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   ({NWS_LANES{accept}}),
      .din   (mst_data),
      .q     (held)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (accept) mem_q <= mst_mem;
         if (accept)           err_q <= 1'b0;
         else if (timeout_hit) err_q <= 1'b1;
      end
   end

   assign in_x0   = (state_q == ST_X0_CMD) || (state_q == ST_X0_WAIT);
   assign in_x1   = (state_q == ST_X1_CMD) || (state_q == ST_X1_WAIT);
   assign in_rst  = (state_q == ST_RESTART);
   assign in_done = (state_q == ST_DONE);
   assign cmd_on  = in_x0 || in_x1;

   assign lane_lat   = {NWS_LANES{accept}};
   assign lane0_oe   = in_x0;
   assign lane1_oe   = in_x1;
   assign copy_dn_en = in_x1;
   assign nar_start  = in_rst;
   assign nar_mem_wr = cmd_on && mem_q;
   assign nar_io_wr  = cmd_on && !mem_q;
   assign nar_a0     = in_x1 || in_rst;
   assign nar_a1     = 1'b0;
   assign nar_bhe_n  = !(in_x0 || in_x1 || in_rst);
   assign nar_data   = in_x0 ? held[0 +: LANE_W] :
                       in_x1 ? held[LANE_W +: LANE_W] : '0;
   assign ack_wide16 = in_done;
   assign ack_wide32 = in_done;
   assign steer_busy = !(state_q == ST_IDLE || state_q == ST_LATCH);
   assign tmo_err    = err_q;

   assert_cmd_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(nar_mem_wr && nar_io_wr));
   assert_restart_then_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nar_start |=> (nar_mem_wr || nar_io_wr) && lane1_oe);
   assert_lane_oe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(lane0_oe && lane1_oe));
   assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wide16 |=> !ack_wide16 && !steer_busy);
   assert_cmd_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lane0_oe || lane1_oe) |-> (nar_start || ack_wide16));
   assert_timeout_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_hit |=> tmo_err && ack_wide32);
endmodule

// File: tb/tb_nws_seq.sv
module tb_nws_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mst_start = 0, mst_is16 = 0, mst_write = 0, mst_mem = 0;
   logic [1:0]  mst_be = 0;
   logic [15:0] mst_data = 0;
   logic        slv_wide16 = 0, slv_wide32 = 0, slv_nows = 0, slv_chrdy = 0;
   logic [7:0]  tmo_limit = 8'd4;
   logic [1:0]  lane_lat;
   logic        lane0_oe, lane1_oe, copy_dn_en, nar_start, nar_mem_wr, nar_io_wr;
   logic        nar_a0, nar_a1, nar_bhe_n, ack_wide16, ack_wide32, steer_busy, tmo_err;
   logic [7:0]  nar_data;

   int n_cmp = 0, n_bad = 0;
   bit err_st = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   nws_seq dut (.*);

   function automatic logic [22:0] ev(input bit lat, oe0, oe1, cp, st, mw, iw,
                                      a0, bhe_n, ack, busy, err, input logic [7:0] d);
      return {{2{lat}}, oe0, oe1, cp, st, mw, iw, a0, 1'b0, bhe_n, ack, ack, busy, err, d};
   endfunction

   function automatic logic [22:0] idle_v(input bit err, input bit lat);
      return ev(lat, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, err, 8'h00);
   endfunction

   task automatic cyc(input logic [22:0] e, input string tag);
      logic [22:0] a;
      #1;
      a = {lane_lat, lane0_oe, lane1_oe, copy_dn_en, nar_start, nar_mem_wr, nar_io_wr,
           nar_a0, nar_a1, nar_bhe_n, ack_wide16, ack_wide32, steer_busy, tmo_err, nar_data};
      n_cmp++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, a, e);
      end
      @(negedge clk);
   endtask

   task automatic xfer(input bit hi, input bit mem, input bit nw, input int w,
                       input int lim, input logic [7:0] d, output bit ab);
      logic [22:0] e;
      ab = 0;
      e = ev(0, !hi, hi, hi, 0, mem, !mem, hi, 0, 0, 1, 0, d);
      slv_nows = nw;
      cyc(e, hi ? "R8" : "R4");
      slv_nows = 0;
      for (int j = 0; j < 1000; j++) begin
         slv_chrdy = (!nw && j == w);
         cyc(e, nw ? "R5" : (j == lim && j < w) ? "R11" : "R6");
         slv_chrdy = 0;
         if (nw || j == w) break;
         if (j == lim) begin ab = 1; break; end
      end
   endtask

   task automatic steer(input bit mem, input logic [1:0] be, input logic [7:0] d0, d1,
                        input bit nwa, input int wa, input bit nwb, input int wb,
                        input int lim);
      bit ab;
      tmo_limit = lim[7:0];
      mst_start = 1; mst_is16 = 1; mst_write = 1; mst_mem = mem;
      mst_be = 0; mst_data = 16'h0; slv_wide16 = 0; slv_wide32 = 0;
      cyc(idle_v(err_st, 0), "R1");
      mst_start = 0; mst_be = be; mst_data = {d1, d0};
      cyc(idle_v(err_st, 1), "R3");
      err_st = 0;
      mst_be = 0; mst_data = ~{d1, d0};
      mst_mem = mem;
      ab = 0;
      if (be[0]) xfer(0, mem, nwa, wa, lim, d0, ab);
      if (be[1] && !ab) begin
         if (be[0]) cyc(ev(0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 8'h00), "R7");
         else       $display("info: single upper lane, restart skipped per R9");
         xfer(1, mem, nwb, wb, lim, d1, ab);
      end
      cyc(ev(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, ab, 8'h00), ab ? "R11" : "R10");
      err_st = ab;
      cyc(idle_v(err_st, 0), "R10");
   endtask

   task automatic nosteer(input bit is16, wr, input logic [1:0] be, input bit w16, w32);
      mst_start = 1; mst_is16 = is16; mst_write = wr; mst_mem = 1;
      cyc(idle_v(err_st, 0), "R2");
      mst_start = 0; mst_be = be; mst_data = 16'hBEEF; slv_wide16 = w16; slv_wide32 = w32;
      cyc(idle_v(err_st, 0), "R2");
      mst_be = 0; slv_wide16 = 0; slv_wide32 = 0; slv_nows = 1; slv_chrdy = 1;
      cyc(idle_v(err_st, 0), "R2");
      slv_nows = 0; slv_chrdy = 0;
      cyc(idle_v(err_st, 0), "R2");
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      cyc(idle_v(0, 0), "R1");
      rst_n = 1;
      @(negedge clk);
      cyc(idle_v(0, 0), "R1");
      // full two-byte memory write, zero-wait then ready after waits
      steer(1, 2'b11, 8'h3C, 8'hA7, 1, 0, 0, 2, 6);
      // I/O write, ready on first wait, then zero-wait with ready low
      steer(0, 2'b11, 8'h51, 8'h9E, 0, 0, 1, 0, 6);
      // single lanes
      steer(1, 2'b01, 8'hC4, 8'h00, 0, 3, 0, 0, 6);
      steer(0, 2'b10, 8'h00, 8'h6B, 0, 0, 0, 1, 6);
      // non-steering cases
      nosteer(1, 1, 2'b11, 1, 0);
      nosteer(1, 1, 2'b11, 0, 1);
      nosteer(0, 1, 2'b11, 0, 0);
      nosteer(1, 0, 2'b11, 0, 0);
      nosteer(1, 1, 2'b00, 0, 0);
      // timeout in first cycle skips the second
      steer(1, 2'b11, 8'h11, 8'h22, 0, 9, 0, 0, 2);
      // flag persists, then clears after next takeover
      steer(1, 2'b11, 8'hF0, 8'h0F, 0, 1, 0, 0, 3);
      // timeout with zero limit in the second cycle
      steer(0, 2'b11, 8'h77, 8'h88, 1, 0, 0, 5, 0);
      steer(1, 2'b10, 8'h00, 8'h5A, 1, 0, 1, 0, 0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule